// File: doc/BRIEF.md
# Asynchronous Parallel Bus Region Timing Sequencer

This block drives the chip-enable, output-enable and write-enable strobes of one memory-mapped region on an asynchronous parallel bus. A host issues single 8-bit or 16-bit reads and writes through a valid/ready request port. Each bus cycle runs through a fixed series of phases: address set-up, enable-to-strobe set-up, active strobe, optional ready-driven wait, hold and pause. Each phase length comes from a register-loaded timing field.

A phase lasts the field value plus one, times a per-region clock multiplier. The device's ready line can stretch the active strobe. Writes are posted into a write queue so that the host is not held up. A read is only taken once every earlier write has left the queue and the sequencer is idle, so bus order always matches request order.

Top module: `pbus_region_seq`

## Requirements
- R1: A phase with timing field value F lasts (F+1)*M clocks, where the multiplier code 0, 1, 2, 3 selects M = 2, 4, 8, 16.
- R2: A cycle begins with an address phase (address driven, `bus_ce_n` high) of `cfg_t_addr` length. It is followed by a set-up phase of `cfg_t_setup` length with `bus_ce_n` low and both strobes high.
- R3: In the active phase of `cfg_t_active` length, `bus_oe_n` is low for a read and `bus_we_n` is low for a write, never both. After the strobe ends, `bus_ce_n` stays low for `cfg_t_rd_hold` (read) or `cfg_t_wr_hold` (write) length.
- R4: After `bus_ce_n` rises, a pause of `cfg_t_pause` length runs, then one idle clock, before the next cycle's address phase can begin.
- R5: With `cfg_wait_en` set, an extra wait phase follows the active count, with the strobe still asserted. While the ready input (after a 2-flop synchroniser) is low, its count restarts, so the phase ends only after `cfg_t_wait` length of continuous ready. With `cfg_wait_en` clear, `bus_rdy` has no effect on any output.
- R6: Read data is captured on the clock edge where the read strobe deasserts. `rsp_valid` is high for the one following clock. A narrow read (`req_wide`=0) returns `bus_din[7:0]` with the upper 8 bits zero.
- R7: Writes are posted into a 16-entry queue. While 16 writes are pending, `req_ready` is low for a write request.
- R8: A read request is accepted (`req_ready` high) only when the queue is empty and the sequencer is idle. Queued writes reach the bus in arrival order before it.
- R9: With `cfg_en` low, `bus_ce_n`, `bus_oe_n` and `bus_we_n` stay high. Queued writes are discarded one per clock, and a read returns zero data with `rsp_valid` on the next clock.
- R10: During and right after reset, all three strobes are high, `rsp_valid` is low, `bus_dout_en` is low and `req_ready` is high.
- R11: During a write, `bus_dout_en` is high from the address phase through the hold phase. A narrow write drives its low byte on `bus_dout[7:0]` with the upper 8 bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Region enable |
| cfg_mult | input | 2 | Multiplier code (M = 2 << code) |
| cfg_wait_en | input | 1 | Ready-driven wait enable |
| cfg_t_addr | input | FLD_W | Address-to-enable time, minus one |
| cfg_t_setup | input | FLD_W | Enable-to-strobe time, minus one |
| cfg_t_active | input | FLD_W | Strobe active time, minus one |
| cfg_t_rd_hold | input | FLD_W | Enable hold after read strobe, minus one |
| cfg_t_wr_hold | input | FLD_W | Enable hold after write strobe, minus one |
| cfg_t_wait | input | FLD_W | Strobe time after ready returns, minus one |
| cfg_t_pause | input | FLD_W | Idle time after enable release, minus one |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | DATA_W | Read data |
| bus_addr | output | ADDR_W | Bus address |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_wide | output | 1 | Width of the current cycle |
| bus_dout | output | DATA_W | Write data to the bus |
| bus_dout_en | output | 1 | Drive enable for bus_dout |
| bus_din | input | DATA_W | Read data from the bus |
| bus_rdy | input | 1 | Device ready, asynchronous |

## Verification
A wrong phase state or count shows up at a strobe edge that lands too early or too late. Because every port is compared every clock, the error is caught at the first affected edge, within one phase length. A wrong queue count shows as `req_ready` in the wrong state on the next request, or as a write cycle that is missing or extra on the bus. A fault in the ready path shows as an active strobe whose length does not match the ready waveform. A capture fault shows in the single clock of `rsp_valid`.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int FLD_W  = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SETUP,
        PH_ACTIVE,
        PH_WAIT,
        PH_HOLD,
        PH_PAUSE
    } phase_e;

    typedef struct packed {
        logic             en;
        logic [1:0]       mult;
        logic             wait_en;
        logic [FLD_W-1:0] t_addr;
        logic [FLD_W-1:0] t_setup;
        logic [FLD_W-1:0] t_active;
        logic [FLD_W-1:0] t_rd_hold;
        logic [FLD_W-1:0] t_wr_hold;
        logic [FLD_W-1:0] t_wait;
        logic [FLD_W-1:0] t_pause;
    } timing_t;

    typedef struct packed {
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_entry_t;

    typedef struct packed {
        logic              write;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } xfer_t;

    // Clock count minus one for a field: (f+1) units of (2 << m) clocks
    function automatic logic [31:0] span_m1(input logic [FLD_W-1:0] f, input logic [1:0] m);
        return ((32'(f) + 32'd1) << (32'(m) + 32'd1)) - 32'd1;
    endfunction

endpackage

// File: rtl/pbus_wfifo.sv
module pbus_wfifo
    import pbus_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   push,
    input  wr_entry_t              push_ent,
    input  logic                   pop,
    output wr_entry_t              head,
    output logic                   full,
    output logic                   empty,
    output logic [$clog2(DEPTH):0] count
);
    localparam int PW = $clog2(DEPTH);

    wr_entry_t         mem [DEPTH];
    logic [PW-1:0]     wp, rp;
    logic              do_push, do_pop;

    assign full    = (count == (PW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_one
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= 1'b1;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= {sr[STAGES-2:0], d};
            end
            assign q = sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pbus_cycle_fsm.sv
module pbus_cycle_fsm
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  timing_t           cfg,
    input  logic              fifo_empty,
    input  wr_entry_t         fifo_head,
    output logic              fifo_pop,
    input  logic              rd_go,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_wide,
    input  logic              rdy_s,
    input  logic [DATA_W-1:0] bus_din,
    output logic              idle,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              dout_en,
    output logic              wide_o,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int CNT_W = FLD_W + 5;

    phase_e            st, st_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    xfer_t             cur, cur_nx;
    logic              rv_nx;
    logic [DATA_W-1:0] rd_nx, rd_cap;
    logic              last;
    logic [FLD_W-1:0]  hold_f;
    logic              in_ce, strobe, drive;

    function automatic logic [CNT_W-1:0] ld(input logic [FLD_W-1:0] f, input logic [1:0] m);
        return CNT_W'(span_m1(f, m));
    endfunction

    assign last   = (cnt == '0);
    assign hold_f = cur.write ? cfg.t_wr_hold : cfg.t_rd_hold;
    assign rd_cap = cur.wide ? bus_din : {{(DATA_W-8){1'b0}}, bus_din[7:0]};

    always_comb begin
        st_nx    = st;
        cnt_nx   = cnt;
        cur_nx   = cur;
        rv_nx    = 1'b0;
        rd_nx    = rsp_data;
        fifo_pop = 1'b0;
        case (st)
            PH_IDLE: begin
                fifo_pop = !fifo_empty;
                if (!cfg.en) begin
                    if (rd_go) begin
                        rv_nx = 1'b1;
                        rd_nx = '0;
                    end
                end else if (!fifo_empty) begin
                    cur_nx = '{write: 1'b1, wide: fifo_head.wide,
                               addr: fifo_head.addr, data: fifo_head.data};
                    st_nx  = PH_ADDR;
                    cnt_nx = ld(cfg.t_addr, cfg.mult);
                end else if (rd_go) begin
                    cur_nx = '{write: 1'b0, wide: rd_wide, addr: rd_addr, data: '0};
                    st_nx  = PH_ADDR;
                    cnt_nx = ld(cfg.t_addr, cfg.mult);
                end
            end
            PH_ADDR: begin
                if (last) begin
                    st_nx  = PH_SETUP;
                    cnt_nx = ld(cfg.t_setup, cfg.mult);
                end else cnt_nx = cnt - 1'b1;
            end
            PH_SETUP: begin
                if (last) begin
                    st_nx  = PH_ACTIVE;
                    cnt_nx = ld(cfg.t_active, cfg.mult);
                end else cnt_nx = cnt - 1'b1;
            end
            PH_ACTIVE: begin
                if (last) begin
                    if (cfg.wait_en) begin
                        st_nx  = PH_WAIT;
                        cnt_nx = ld(cfg.t_wait, cfg.mult);
                    end else begin
                        st_nx  = PH_HOLD;
                        cnt_nx = ld(hold_f, cfg.mult);
                        if (!cur.write) begin
                            rv_nx = 1'b1;
                            rd_nx = rd_cap;
                        end
                    end
                end else cnt_nx = cnt - 1'b1;
            end
            PH_WAIT: begin
                if (!rdy_s) begin
                    cnt_nx = ld(cfg.t_wait, cfg.mult);
                end else if (last) begin
                    st_nx  = PH_HOLD;
                    cnt_nx = ld(hold_f, cfg.mult);
                    if (!cur.write) begin
                        rv_nx = 1'b1;
                        rd_nx = rd_cap;
                    end
                end else cnt_nx = cnt - 1'b1;
            end
            PH_HOLD: begin
                if (last) begin
                    st_nx  = PH_PAUSE;
                    cnt_nx = ld(cfg.t_pause, cfg.mult);
                end else cnt_nx = cnt - 1'b1;
            end
            PH_PAUSE: begin
                if (last) st_nx = PH_IDLE;
                else      cnt_nx = cnt - 1'b1;
            end
            default: st_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PH_IDLE;
            cnt       <= '0;
            cur       <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            st        <= st_nx;
            cnt       <= cnt_nx;
            cur       <= cur_nx;
            rsp_valid <= rv_nx;
            rsp_data  <= rd_nx;
        end
    end

    assign in_ce  = (st == PH_SETUP) || (st == PH_ACTIVE) || (st == PH_WAIT) || (st == PH_HOLD);
    assign strobe = (st == PH_ACTIVE) || (st == PH_WAIT);
    assign drive  = in_ce || (st == PH_ADDR);

    assign idle     = (st == PH_IDLE);
    assign ce_n     = !(cfg.en && in_ce);
    assign oe_n     = !(cfg.en && strobe && !cur.write);
    assign we_n     = !(cfg.en && strobe && cur.write);
    assign bus_addr = cur.addr;
    assign wide_o   = cur.wide;
    assign bus_dout = cur.wide ? cur.data : {{(DATA_W-8){1'b0}}, cur.data[7:0]};
    assign dout_en  = cfg.en && cur.write && drive;
endmodule

// File: rtl/pbus_region_seq.sv
module pbus_region_seq
    import pbus_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic [1:0]        cfg_mult,
    input  logic              cfg_wait_en,
    input  logic [FLD_W-1:0]  cfg_t_addr,
    input  logic [FLD_W-1:0]  cfg_t_setup,
    input  logic [FLD_W-1:0]  cfg_t_active,
    input  logic [FLD_W-1:0]  cfg_t_rd_hold,
    input  logic [FLD_W-1:0]  cfg_t_wr_hold,
    input  logic [FLD_W-1:0]  cfg_t_wait,
    input  logic [FLD_W-1:0]  cfg_t_pause,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ce_n,
    output logic              bus_oe_n,
    output logic              bus_we_n,
    output logic              bus_wide,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_rdy
);
    localparam int CW = $clog2(DEPTH) + 1;

    timing_t          cfg;
    wr_entry_t        head, push_ent;
    logic             fifo_full, fifo_empty, fifo_pop, idle, rdy_s, wr_push, rd_go;
    logic [CW-1:0]    fifo_cnt;

    assign cfg = '{en: cfg_en, mult: cfg_mult, wait_en: cfg_wait_en,
                   t_addr: cfg_t_addr, t_setup: cfg_t_setup, t_active: cfg_t_active,
                   t_rd_hold: cfg_t_rd_hold, t_wr_hold: cfg_t_wr_hold,
                   t_wait: cfg_t_wait, t_pause: cfg_t_pause};

    assign req_ready = req_write ? !fifo_full : (idle && fifo_empty);
    assign wr_push   = req_valid && req_write && !fifo_full;
    assign rd_go     = req_valid && !req_write && idle && fifo_empty;
    assign push_ent  = '{wide: req_wide, addr: req_addr, data: req_wdata};

    pbus_wfifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (wr_push),
        .push_ent (push_ent),
        .pop      (fifo_pop),
        .head     (head),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .count    (fifo_cnt)
    );

    pbus_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_rdy),
        .q   (rdy_s)
    );

    pbus_cycle_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .fifo_empty (fifo_empty),
        .fifo_head  (head),
        .fifo_pop   (fifo_pop),
        .rd_go      (rd_go),
        .rd_addr    (req_addr),
        .rd_wide    (req_wide),
        .rdy_s      (rdy_s),
        .bus_din    (bus_din),
        .idle       (idle),
        .ce_n       (bus_ce_n),
        .oe_n       (bus_oe_n),
        .we_n       (bus_we_n),
        .bus_addr   (bus_addr),
        .bus_dout   (bus_dout),
        .dout_en    (bus_dout_en),
        .wide_o     (bus_wide),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );
endmodule

// File: rtl/pbus_region_chk.sv
module pbus_region_chk #(
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cfg_en,
    input logic                   cfg_wait_en,
    input logic                   req_valid,
    input logic                   req_write,
    input logic                   req_ready,
    input logic                   ce_n,
    input logic                   oe_n,
    input logic                   we_n,
    input logic                   rdy_s,
    input logic [$clog2(DEPTH):0] fifo_cnt
);
    localparam int CW = $clog2(DEPTH) + 1;

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n));

    assert_strobe_in_ce_R3: assert property (@(posedge clk) disable iff (rst)
        (!oe_n || !we_n) |-> !ce_n);

    assert_setup_before_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(oe_n) || $fell(we_n)) |-> $past(!ce_n));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CW'(DEPTH));

    assert_full_refuse_R7: assert property (@(posedge clk) disable iff (rst)
        (fifo_cnt == CW'(DEPTH) && req_write) |-> !req_ready);

    assert_read_after_drain_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_ready) |-> (fifo_cnt == '0));

    assert_ready_stretch_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_wait_en && !rdy_s && !(oe_n && we_n)) |=> !(oe_n && we_n));

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |-> (ce_n && oe_n && we_n));
endmodule

bind pbus_region_seq pbus_region_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_en      (cfg_en),
    .cfg_wait_en (cfg_wait_en),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_ready   (req_ready),
    .ce_n        (bus_ce_n),
    .oe_n        (bus_oe_n),
    .we_n        (bus_we_n),
    .rdy_s       (rdy_s),
    .fifo_cnt    (fifo_cnt)
);

// File: tb/pbus_region_seq_tb.sv
module pbus_region_seq_tb;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 1'b1, cfg_wait_en = 1'b0;
    logic [1:0]  cfg_mult = 2'd0;
    logic [5:0]  t_addr = 0, t_setup = 0, t_active = 0, t_rdh = 0, t_wrh = 0, t_wait = 0, t_pause = 0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b1;
    logic [15:0] req_addr = 16'h0, req_wdata = 16'h0, bus_din = 16'hA5C3;
    logic        bus_rdy = 1'b1;
    logic        req_ready, rsp_valid, bus_ce_n, bus_oe_n, bus_we_n, bus_wide, bus_dout_en;
    logic [15:0] rsp_data, bus_addr, bus_dout;

    always #5 clk = ~clk;

    pbus_region_seq #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_mult(cfg_mult), .cfg_wait_en(cfg_wait_en),
        .cfg_t_addr(t_addr), .cfg_t_setup(t_setup), .cfg_t_active(t_active),
        .cfg_t_rd_hold(t_rdh), .cfg_t_wr_hold(t_wrh), .cfg_t_wait(t_wait), .cfg_t_pause(t_pause),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bus_addr(bus_addr), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_wide(bus_wide), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .bus_din(bus_din), .bus_rdy(bus_rdy)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // phases: 0 idle, 1 addr, 2 setup, 3 active, 4 wait, 5 hold, 6 pause
    int          m_st = 0, m_cnt = 0;
    bit          m_wr = 0, m_wide = 0, m_rv = 0, s1 = 1, s2 = 1;
    logic [15:0] m_addr = 0, m_data = 0, m_rd = 0;
    logic [32:0] q[$];

    function automatic int plen(input int f);
        return (f + 1) * (2 << cfg_mult);
    endfunction

    task automatic m_end_strobe();
        m_st  = 5;
        m_cnt = plen(m_wr ? int'(t_wrh) : int'(t_rdh)) - 1;
        if (!m_wr) begin
            m_rv = 1;
            m_rd = m_wide ? bus_din : {8'h00, bus_din[7:0]};
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_wr = 0; m_wide = 0; m_rv = 0;
            m_addr = 0; m_data = 0; m_rd = 0; s1 = 1; s2 = 1;
            q.delete();
        end else begin
            bit wr_acc, rd_acc;
            logic [32:0] e;
            wr_acc = req_valid && req_write && (q.size() < DEPTH);
            rd_acc = req_valid && !req_write && (m_st == 0) && (q.size() == 0);
            m_rv = 0;
            case (m_st)
                0: begin
                    if (q.size() > 0) begin
                        e = q.pop_front();
                        if (cfg_en) begin
                            m_wr = 1; m_wide = e[32]; m_addr = e[31:16]; m_data = e[15:0];
                            m_st = 1; m_cnt = plen(t_addr) - 1;
                        end
                    end else if (rd_acc) begin
                        if (cfg_en) begin
                            m_wr = 0; m_wide = req_wide; m_addr = req_addr; m_data = 0;
                            m_st = 1; m_cnt = plen(t_addr) - 1;
                        end else begin
                            m_rv = 1; m_rd = 0;
                        end
                    end
                end
                1: if (m_cnt == 0) begin m_st = 2; m_cnt = plen(t_setup) - 1; end else m_cnt--;
                2: if (m_cnt == 0) begin m_st = 3; m_cnt = plen(t_active) - 1; end else m_cnt--;
                3: if (m_cnt == 0) begin
                       if (cfg_wait_en) begin m_st = 4; m_cnt = plen(t_wait) - 1; end
                       else m_end_strobe();
                   end else m_cnt--;
                4: if (!s2) m_cnt = plen(t_wait) - 1;
                   else if (m_cnt == 0) m_end_strobe();
                   else m_cnt--;
                5: if (m_cnt == 0) begin m_st = 6; m_cnt = plen(t_pause) - 1; end else m_cnt--;
                6: if (m_cnt == 0) m_st = 0; else m_cnt--;
                default: m_st = 0;
            endcase
            if (wr_acc) q.push_back({req_wide, req_addr, req_wdata});
            s2 = s1;
            s1 = bus_rdy;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit ce_on, st_on, drv;
            ce_on = cfg_en && (m_st >= 2) && (m_st <= 5);
            st_on = cfg_en && (m_st == 3 || m_st == 4);
            drv   = cfg_en && m_wr && (m_st >= 1) && (m_st <= 5);
            chk("R2", "bus_ce_n", bus_ce_n, !ce_on);
            chk("R3", "bus_oe_n", bus_oe_n, !(st_on && !m_wr));
            chk("R3", "bus_we_n", bus_we_n, !(st_on && m_wr));
            chk("R2", "bus_addr", bus_addr, m_addr);
            chk("R11", "bus_dout_en", bus_dout_en, drv);
            chk("R11", "bus_dout", bus_dout, m_wide ? m_data : {8'h00, m_data[7:0]});
            chk("R6", "bus_wide", bus_wide, m_wide);
            chk("R6", "rsp_valid", rsp_valid, m_rv);
            chk("R6", "rsp_data", rsp_data, m_rd);
            chk("R8", "req_ready", req_ready,
                req_write ? (q.size() < DEPTH) : (m_st == 0 && q.size() == 0));
        end
    end

    // strobe and gap monitors (in clocks)
    int oe_run = 0, we_run = 0, ceh_run = 0, last_oe = 0, last_we = 0, last_ceh = 0;
    int we_falls = 0, ce_lows = 0;
    bit prev_we = 1, ce_seen = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!bus_oe_n) oe_run++; else if (oe_run > 0) begin last_oe = oe_run; oe_run = 0; end
            if (!bus_we_n) we_run++; else if (we_run > 0) begin last_we = we_run; we_run = 0; end
            if (!bus_we_n && prev_we) we_falls++;
            prev_we = bus_we_n;
            if (bus_ce_n) ceh_run++;
            else begin
                if (ce_seen && ceh_run > 0) last_ceh = ceh_run;
                ceh_run = 0; ce_seen = 1; ce_lows++;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    int stalls = 0;
    task automatic send(input bit w, input bit wide, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        req_valid = 1; req_write = w; req_wide = wide; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin
            stalls++;
            @(negedge clk); #2;
        end
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic wait_rsp();
        do @(negedge clk); while (!rsp_valid);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(m_st == 0 && q.size() == 0));
        repeat (2) @(negedge clk);
    endtask

    task automatic set_t(input logic [1:0] m, input int a, input int s, input int act,
                         input int rh, input int wh, input int wt, input int p);
        cfg_mult = m; t_addr = 6'(a); t_setup = 6'(s); t_active = 6'(act);
        t_rdh = 6'(rh); t_wrh = 6'(wh); t_wait = 6'(wt); t_pause = 6'(p);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R4 watchdog expired: actual=hung expected=done");
        finish_run();
    end

    initial begin
        set_t(2'd0, 0, 0, 2, 1, 2, 0, 1);
        repeat (4) @(negedge clk);
        // R10: reset state
        chk("R10", "ce_n in reset", bus_ce_n, 1);
        chk("R10", "oe_n in reset", bus_oe_n, 1);
        chk("R10", "we_n in reset", bus_we_n, 1);
        chk("R10", "rsp_valid in reset", rsp_valid, 0);
        chk("R10", "dout_en in reset", bus_dout_en, 0);
        #1 rst = 0;
        @(negedge clk);
        chk("R10", "req_ready after reset", req_ready, 1);

        // R1/R3: write, active field 2, M=2 -> 6 clocks
        send(1, 1, 16'h0040, 16'h1234);
        wait_idle();
        chk("R1", "write strobe clocks", last_we, 6);

        // R6: wide read captures full word
        bus_din = 16'hA5C3;
        send(0, 1, 16'h0042, 16'h0);
        wait_rsp();
        chk("R6", "wide read data", rsp_data, 16'hA5C3);
        wait_idle();
        chk("R3", "read strobe clocks", last_oe, 6);

        // R1: multiplier 4x, active 3 -> 16 clocks; 16x, active 1 -> 32
        set_t(2'd1, 1, 0, 3, 0, 0, 0, 0);
        send(1, 1, 16'h0100, 16'hCAFE);
        wait_idle();
        chk("R1", "4x strobe clocks", last_we, 16);
        set_t(2'd3, 0, 0, 1, 0, 0, 0, 0);
        send(1, 1, 16'h0102, 16'hF00D);
        wait_idle();
        chk("R1", "16x strobe clocks", last_we, 32);

        // R11/R6: narrow write and read
        set_t(2'd0, 1, 1, 1, 1, 1, 0, 1);
        send(1, 0, 16'h0055, 16'hBEEF);
        wait_idle();
        send(0, 0, 16'h0056, 16'h0);
        wait_rsp();
        chk("R6", "narrow read data", rsp_data, 16'h00C3);
        wait_idle();

        // R7/R8/R4: fill the queue, then read behind the writes
        set_t(2'd1, 3, 3, 3, 3, 3, 3, 3);
        stalls = 0;
        we_falls = 0;
        for (int i = 0; i < 20; i++) send(1, 1, 16'h0200 + 16'(i), 16'h1000 + 16'(i));
        chk("R7", "write stalls seen", int'(stalls > 0), 1);
        send(0, 1, 16'h0300, 16'h0);
        wait_rsp();
        chk("R8", "writes before read", we_falls, 20);
        chk("R4", "enable-high gap clocks", last_ceh, 33);
        wait_idle();

        // R5: ready held low stretches the read strobe
        set_t(2'd0, 0, 0, 1, 0, 0, 1, 0);
        cfg_wait_en = 1;
        bus_rdy = 0;
        send(0, 1, 16'h0400, 16'h0);
        do @(negedge clk); while (bus_oe_n);
        repeat (30) @(negedge clk);
        #1 bus_rdy = 1;
        wait_rsp();
        wait_idle();
        chk("R5", "stretched strobe >= 30", int'(last_oe >= 30), 1);

        // R5: wait disabled, ready low ignored
        cfg_wait_en = 0;
        bus_rdy = 0;
        send(0, 1, 16'h0402, 16'h0);
        wait_rsp();
        wait_idle();
        chk("R5", "unstretched strobe clocks", last_oe, 4);
        bus_rdy = 1;

        // R9: disabled region
        cfg_en = 0;
        ce_lows = 0;
        for (int i = 0; i < 3; i++) send(1, 1, 16'h0500 + 16'(i), 16'h7777);
        send(0, 1, 16'h0510, 16'h0);
        wait_rsp();
        chk("R9", "disabled read data", rsp_data, 16'h0000);
        wait_idle();
        chk("R9", "enable low clocks while disabled", ce_lows, 0);
        cfg_en = 1;

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule